// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer with Debug Hold

The block is a watchdog built from a prescaler and a timeout counter, each 32 bits wide. Software writes a prescale limit and a timeout limit, starts the watchdog through a control word that must carry a fixed 16-bit key, and then writes a restart command often enough to keep the count from expiring. If the count expires, a sticky reset request goes to the chip's reset generator and stays asserted until the block itself is reset.

Both counters run on an always-on safe clock. The register interface runs on the system bus clock. Two kinds of crossing join the domains. Restart commands and timeout events travel as toggle-based pulses. Control bits travel through two-flop level synchronizers. Limit values are copied into the safe domain only while the watchdog is stopped. When the debug bit of the control word is set, a timeout never requests a reset. It raises a level interrupt instead, if the interrupt enable is set. With the hold bit also set, both counters freeze until the hold is released.

Top module: `safe_watchdog`

## Requirements
- R1: After `rst_n` is released, `wdt_rst_req` and `wdt_irq` are both low.
- R2: While running (control bit 0 set) and not in debug mode, `wdt_rst_req` rises once (prescale limit + 1) x (timeout limit) safe-clock cycles have passed without a restart, plus a few cycles of synchronizer latency. It does not rise earlier.
- R3: A write to address 3 (any data) clears both counters. Restarts issued more often than the timeout period keep `wdt_rst_req` low.
- R4: A write to the control word at address 0 takes effect only when data bits [31:16] equal 16'hC35A. Any other value leaves the control word unchanged.
- R5: Once high, `wdt_rst_req` stays high until `rst_n` is asserted. Stopping the watchdog or issuing a restart does not lower it.
- R6: With debug mode set (control bit 2), a timeout never raises `wdt_rst_req`. The timeout sets `wdt_irq` only when the interrupt-enable bit (address 4, data bit 0) is 1.
- R7: `wdt_irq` stays high until a write to address 5 (any data) clears it. A timeout that arrives in the same bus cycle as a clear write wins, and `wdt_irq` is high in the following cycle.
- R8: With debug mode and hold (control bit 1) both set, both counters keep their values. When the hold is released, counting resumes from the held values and does not start again from zero.
- R9: The limits written at address 1 (timeout) and address 2 (prescale) reach the counters only while the watchdog is stopped. Limit writes made while it is running do not change the current period.
- R10: The prescaler counts from 0 up to its limit and wraps. Each wrap advances the timeout counter. A prescale limit of 0 gives one timeout step per safe-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | System bus clock for the register interface |
| clk_safe | input | 1 | Always-on safe clock for the counters |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register address: 0 control, 1 timeout limit, 2 prescale limit, 3 restart, 4 interrupt enable, 5 interrupt clear |
| bus_wdata | input | 32 | Write data |
| wdt_rst_req | output | 1 | Sticky reset request to the reset generator |
| wdt_irq | output | 1 | Timeout interrupt in debug mode, level |

## Verification
Two functions can land in the same bus cycle: a debug-mode timeout arriving from the safe domain to set the interrupt, and a software write that clears it. The bench provokes this by holding a clear write on the bus for two hundred consecutive cycles while debug timeouts keep arriving, so every arrival coincides with a clear. The design passes only if `wdt_irq` is seen high at least once during that window, which shows that the set wins. A design where the clear wins would keep the output low throughout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_CTRL    = 0;
  localparam int unsigned ADDR_TMO     = 1;
  localparam int unsigned ADDR_PRE     = 2;
  localparam int unsigned ADDR_RESTART = 3;
  localparam int unsigned ADDR_IRQ_EN  = 4;
  localparam int unsigned ADDR_IRQ_CLR = 5;

  localparam int unsigned CTRL_W    = 3;
  localparam int unsigned CTRL_RUN  = 0;
  localparam int unsigned CTRL_HOLD = 1;
  localparam int unsigned CTRL_DBG  = 2;
endpackage

// File: rtl/wdt_sync_bits.sv
module wdt_sync_bits #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_pulse_xfer.sv
module wdt_pulse_xfer #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse
);
  localparam int unsigned SH_W = STAGES + 1;

  logic            src_tgl;
  logic [SH_W-1:0] dst_sh;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)         src_tgl <= 1'b0;
    else if (src_pulse) src_tgl <= ~src_tgl;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) dst_sh <= '0;
    else        dst_sh <= {dst_sh[SH_W-2:0], src_tgl};
  end

  assign dst_pulse = dst_sh[SH_W-1] ^ dst_sh[SH_W-2];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
  import wdt_pkg::*;
#(
  parameter int unsigned          DATA_W = 32,
  parameter int unsigned          ADDR_W = 3,
  parameter int unsigned          TMO_W  = 32,
  parameter int unsigned          PRE_W  = 32,
  parameter int unsigned          KEY_W  = 16,
  parameter logic [KEY_W-1:0]     KEY    = 16'hC35A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tmo_ev,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [TMO_W-1:0]  tmo_lim_o,
  output logic [PRE_W-1:0]  pre_lim_o,
  output logic              restart_o,
  output logic              irq_o
);
  function automatic logic key_matches(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: KEY_W] == KEY;
  endfunction

  logic wr_ctrl, wr_tmo, wr_pre, wr_en, wr_clr, key_ok;
  logic irq_en_q;

  assign wr_ctrl   = wr && (addr == ADDR_W'(ADDR_CTRL));
  assign wr_tmo    = wr && (addr == ADDR_W'(ADDR_TMO));
  assign wr_pre    = wr && (addr == ADDR_W'(ADDR_PRE));
  assign wr_en     = wr && (addr == ADDR_W'(ADDR_IRQ_EN));
  assign wr_clr    = wr && (addr == ADDR_W'(ADDR_IRQ_CLR));
  assign restart_o = wr && (addr == ADDR_W'(ADDR_RESTART));
  assign key_ok    = key_matches(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o    <= '0;
      tmo_lim_o <= '0;
      pre_lim_o <= '0;
      irq_en_q  <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      if (wr_ctrl && key_ok) ctrl_o    <= wdata[CTRL_W-1:0];
      if (wr_tmo)            tmo_lim_o <= wdata[TMO_W-1:0];
      if (wr_pre)            pre_lim_o <= wdata[PRE_W-1:0];
      if (wr_en)             irq_en_q  <= wdata[0];
      irq_o <= (irq_o && !wr_clr) || (tmo_ev && irq_en_q);
    end
  end

  assert_key_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !key_ok) |=> $stable(ctrl_o));
  assert_irq_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_ev && irq_en_q) |=> irq_o);
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !tmo_ev) |=> !irq_o);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_clr) |=> irq_o);
endmodule

// File: rtl/wdt_safe_core.sv
module wdt_safe_core
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W = 32,
  parameter int unsigned PRE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_s,
  input  logic [TMO_W-1:0]  tmo_lim_bus,
  input  logic [PRE_W-1:0]  pre_lim_bus,
  input  logic              restart_p,
  output logic              dbg_ev,
  output logic              rst_req
);
  function automatic logic pre_wraps(input logic [PRE_W-1:0] c, input logic [PRE_W-1:0] l);
    return c >= l;
  endfunction

  function automatic logic tmo_reached(input logic [TMO_W-1:0] c, input logic [TMO_W-1:0] l);
    logic [TMO_W:0] nx;
    nx = {1'b0, c} + {{TMO_W{1'b0}}, 1'b1};
    return nx >= {1'b0, l};
  endfunction

  logic [TMO_W-1:0] tmo_cnt, tmo_lim;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic run_s, hold_s, dbg_s, paused, wrap, tmo_hit;

  assign run_s   = ctrl_s[CTRL_RUN];
  assign hold_s  = ctrl_s[CTRL_HOLD];
  assign dbg_s   = ctrl_s[CTRL_DBG];
  assign paused  = dbg_s && hold_s;
  assign wrap    = pre_wraps(pre_cnt, pre_lim);
  assign tmo_hit = run_s && !restart_p && !paused && wrap && tmo_reached(tmo_cnt, tmo_lim);
  assign dbg_ev  = tmo_hit && dbg_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cnt <= '0;
      pre_cnt <= '0;
      tmo_lim <= '0;
      pre_lim <= '0;
      rst_req <= 1'b0;
    end else begin
      if (!run_s) begin
        tmo_cnt <= '0;
        pre_cnt <= '0;
        tmo_lim <= tmo_lim_bus;
        pre_lim <= pre_lim_bus;
      end else if (restart_p) begin
        tmo_cnt <= '0;
        pre_cnt <= '0;
      end else if (!paused) begin
        if (wrap) begin
          pre_cnt <= '0;
          tmo_cnt <= tmo_hit ? '0 : tmo_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
      if (tmo_hit && !dbg_s) rst_req <= 1'b1;
    end
  end

  assert_sticky_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  assert_dbg_no_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_s && !rst_req) |=> !rst_req);
  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && restart_p) |=> (tmo_cnt == '0 && pre_cnt == '0));
  assert_hit_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (tmo_cnt == '0 && pre_cnt == '0));
  assert_pause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && paused && !restart_p) |=> ($stable(tmo_cnt) && $stable(pre_cnt)));
  assert_limits_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && $past(run_s)) |-> ($stable(tmo_lim) && $stable(pre_lim)));
endmodule

// File: rtl/safe_watchdog.sv
module safe_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned      DATA_W  = 32,
  parameter int unsigned      ADDR_W  = 3,
  parameter int unsigned      TMO_W   = 32,
  parameter int unsigned      PRE_W   = 32,
  parameter int unsigned      KEY_W   = 16,
  parameter logic [KEY_W-1:0] KEY     = 16'hC35A,
  parameter int unsigned      SYNC_ST = 2
) (
  input  logic              clk_bus,
  input  logic              clk_safe,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wdt_rst_req,
  output logic              wdt_irq
);
  logic [CTRL_W-1:0] ctrl_bus, ctrl_safe;
  logic [TMO_W-1:0]  tmo_lim_bus;
  logic [PRE_W-1:0]  pre_lim_bus;
  logic restart_bus, restart_safe, dbg_ev_safe, dbg_ev_bus;

  wdt_bus_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_W(TMO_W), .PRE_W(PRE_W),
    .KEY_W(KEY_W), .KEY(KEY)
  ) u_regs (
    .clk(clk_bus), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tmo_ev(dbg_ev_bus), .ctrl_o(ctrl_bus), .tmo_lim_o(tmo_lim_bus),
    .pre_lim_o(pre_lim_bus), .restart_o(restart_bus), .irq_o(wdt_irq)
  );

  wdt_sync_bits #(.W(CTRL_W), .STAGES(SYNC_ST)) u_ctrl_sync (
    .clk(clk_safe), .rst_n(rst_n), .d(ctrl_bus), .q(ctrl_safe)
  );

  wdt_pulse_xfer #(.STAGES(SYNC_ST)) u_restart_xfer (
    .src_clk(clk_bus), .dst_clk(clk_safe), .rst_n(rst_n),
    .src_pulse(restart_bus), .dst_pulse(restart_safe)
  );

  wdt_pulse_xfer #(.STAGES(SYNC_ST)) u_event_xfer (
    .src_clk(clk_safe), .dst_clk(clk_bus), .rst_n(rst_n),
    .src_pulse(dbg_ev_safe), .dst_pulse(dbg_ev_bus)
  );

  wdt_safe_core #(.TMO_W(TMO_W), .PRE_W(PRE_W)) u_core (
    .clk(clk_safe), .rst_n(rst_n), .ctrl_s(ctrl_safe),
    .tmo_lim_bus(tmo_lim_bus), .pre_lim_bus(pre_lim_bus),
    .restart_p(restart_safe), .dbg_ev(dbg_ev_safe), .rst_req(wdt_rst_req)
  );
endmodule

// File: tb/test_safe_watchdog.sv
`timescale 1ns/1ps
module test_safe_watchdog;
  logic        clk_bus = 1'b0, clk_safe = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        wdt_rst_req, wdt_irq;
  int checks = 0, errors = 0;

  localparam logic [15:0] GOOD_KEY = 16'hC35A;
  localparam logic [2:0]  M_RUN = 3'b001, M_HOLD = 3'b010, M_DBG = 3'b100;

  always #10 clk_bus  = ~clk_bus;
  always #16 clk_safe = ~clk_safe;

  safe_watchdog i_safe_watchdog (
    .clk_bus(clk_bus), .clk_safe(clk_safe), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_bus(input int n);
    repeat (n) @(negedge clk_bus);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_wr = 1'b0;
  endtask

  task automatic set_ctrl(input logic [15:0] key, input logic [2:0] mode);
    bus_write(3'd0, {key, 13'd0, mode});
  endtask

  task automatic do_reset();
    @(negedge clk_bus);
    rst_n = 1'b0;
    wait_bus(4);
    rst_n = 1'b1;
    wait_bus(2);
  endtask

  task automatic setup(input logic [31:0] tmo, input logic [31:0] pre);
    bus_write(3'd1, tmo);
    bus_write(3'd2, pre);
  endtask

  // R1: reset state
  task automatic t_reset_state();
    do_reset();
    chk("R1", "rst_req after reset", wdt_rst_req, 1'b0);
    chk("R1", "irq after reset", wdt_irq, 1'b0);
  endtask

  // R2, R5: basic timeout and stickiness
  task automatic t_timeout_sticky();
    do_reset();
    setup(32'd10, 32'd3);
    set_ctrl(GOOD_KEY, M_RUN);
    wait_bus(50);
    chk("R2", "no early reset request", wdt_rst_req, 1'b0);
    wait_bus(45);
    chk("R2", "reset request after period", wdt_rst_req, 1'b1);
    set_ctrl(GOOD_KEY, 3'b000);
    bus_write(3'd3, 32'd0);
    wait_bus(20);
    chk("R5", "reset request sticky after stop and restart", wdt_rst_req, 1'b1);
    do_reset();
    chk("R5", "reset request cleared by rst_n", wdt_rst_req, 1'b0);
  endtask

  // R3: periodic restart
  task automatic t_restart();
    do_reset();
    setup(32'd10, 32'd3);
    set_ctrl(GOOD_KEY, M_RUN);
    for (int k = 0; k < 8; k++) begin
      wait_bus(28);
      bus_write(3'd3, 32'hFFFF_FFFF);
    end
    chk("R3", "restarts keep reset request low", wdt_rst_req, 1'b0);
    wait_bus(100);
    chk("R3", "reset request once restarts stop", wdt_rst_req, 1'b1);
  endtask

  // R4: key guard
  task automatic t_key();
    do_reset();
    setup(32'd10, 32'd3);
    set_ctrl(16'hC35B, M_RUN);
    wait_bus(150);
    chk("R4", "wrong key ignored", wdt_rst_req, 1'b0);
    set_ctrl(16'h0000, M_RUN);
    wait_bus(150);
    chk("R4", "zero key ignored", wdt_rst_req, 1'b0);
    set_ctrl(GOOD_KEY, M_RUN);
    wait_bus(100);
    chk("R4", "good key starts watchdog", wdt_rst_req, 1'b1);
  endtask

  // R10: prescale scaling
  task automatic t_scaling();
    do_reset();
    setup(32'd10, 32'd0);
    set_ctrl(GOOD_KEY, M_RUN);
    wait_bus(10);
    chk("R10", "prescale 0 not before 10 cycles", wdt_rst_req, 1'b0);
    wait_bus(25);
    chk("R10", "prescale 0 fires after ~10 cycles", wdt_rst_req, 1'b1);
    do_reset();
    setup(32'd10, 32'd7);
    set_ctrl(GOOD_KEY, M_RUN);
    wait_bus(115);
    chk("R10", "prescale 7 not before 80 cycles", wdt_rst_req, 1'b0);
    wait_bus(45);
    chk("R10", "prescale 7 fires after ~80 cycles", wdt_rst_req, 1'b1);
  endtask

  // R9: limits frozen while running
  task automatic t_cfg_frozen();
    do_reset();
    setup(32'd10, 32'd3);
    set_ctrl(GOOD_KEY, M_RUN);
    wait_bus(8);
    setup(32'd1000, 32'd3);
    wait_bus(85);
    chk("R9", "limit write while running ignored", wdt_rst_req, 1'b1);
  endtask

  // R6, R7: debug mode
  task automatic t_debug();
    do_reset();
    setup(32'd10, 32'd3);
    set_ctrl(GOOD_KEY, M_DBG | M_RUN);
    wait_bus(200);
    chk("R6", "debug without enable: no reset request", wdt_rst_req, 1'b0);
    chk("R6", "debug without enable: no irq", wdt_irq, 1'b0);
    set_ctrl(GOOD_KEY, 3'b000);
    bus_write(3'd4, 32'd1);
    set_ctrl(GOOD_KEY, M_DBG | M_RUN);
    wait_bus(95);
    chk("R6", "debug with enable raises irq", wdt_irq, 1'b1);
    chk("R6", "debug suppresses reset request", wdt_rst_req, 1'b0);
    bus_write(3'd5, 32'd0);
    chk("R7", "clear lowers irq", wdt_irq, 1'b0);
    wait_bus(75);
    chk("R7", "irq raised again by next timeout", wdt_irq, 1'b1);
    wait_bus(10);
    chk("R7", "irq level held without clear", wdt_irq, 1'b1);
  endtask

  // R8: pause and resume
  task automatic t_pause();
    do_reset();
    setup(32'd10, 32'd3);
    bus_write(3'd4, 32'd1);
    set_ctrl(GOOD_KEY, M_DBG | M_RUN);
    wait_bus(40);
    set_ctrl(GOOD_KEY, M_DBG | M_HOLD | M_RUN);
    wait_bus(200);
    chk("R8", "hold stops timeouts", wdt_irq, 1'b0);
    set_ctrl(GOOD_KEY, M_DBG | M_RUN);
    wait_bus(45);
    chk("R8", "resume from held count", wdt_irq, 1'b1);
  endtask

  // R7: set wins over simultaneous clear
  task automatic t_clash();
    logic seen;
    seen = 1'b0;
    do_reset();
    setup(32'd1, 32'd15);
    bus_write(3'd4, 32'd1);
    set_ctrl(GOOD_KEY, M_DBG | M_RUN);
    @(negedge clk_bus);
    bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'd0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_bus);
      if (wdt_irq) seen = 1'b1;
    end
    bus_wr = 1'b0;
    chk("R7", "timeout during continuous clear still sets irq", seen, 1'b1);
  endtask

  initial begin
    wait_bus(2);
    t_reset_state();
    t_timeout_sticky();
    t_restart();
    t_key();
    t_scaling();
    t_cfg_frozen();
    t_debug();
    t_pause();
    t_clash();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_bus);
    errors++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule